// File: doc/BRIEF.md
# PLL Relock Sequencer

This block governs a change of PLL multiplier after a write to the PLL control register. It runs on the oscillator clock. When software writes a new setting, the block directs the downstream clock mux to the oscillator clock divided by two. It keeps that fallback for a fixed lock interval, then selects the multiplied PLL clock at the newly written ratio. The multiplier applied is the register value shifted right by one bit.

The block contains no analog PLL, no divider and no glitch-free mux. It only produces the select code, the multiplier now in use and a busy flag that software can poll. A register setting whose multiplier comes out as zero requests bypass. Bypass takes effect at once and starts no lock interval.

Top module: `pll_relock_seq`

## Requirements
- R1: After reset the control register holds 0, `lock_busy_o` is low, `clk_sel_o` is 2 (bypass) and `mult_o` is 0.
- R2: A write whose data differs from the register and has `wr_data_i >> 1` nonzero raises `lock_busy_o` and sets `clk_sel_o` to 0 (oscillator divided by two) in the cycle after the write edge.
- R3: `lock_busy_o` stays high for exactly `LOCK_CYCLES` cycles (131072 by default) counted from that write edge, then falls.
- R4: When the lock interval ends, `clk_sel_o` becomes 1 (PLL) and `mult_o` becomes `wr_data_i >> 1`. Register value 4 gives 2, and 8 gives 4.
- R5: `mult_o` keeps the previously applied multiplier before the write and throughout the lock interval.
- R6: A write whose data differs from the register and has `wr_data_i >> 1` equal to zero (values 0 or 1) sets `clk_sel_o` to 2 and `mult_o` to 0 on the next cycle. It starts no lock interval and cancels any lock interval in progress.
- R7: A write of the value already in the register is ignored: no outputs change, and a running lock interval is neither restarted nor shortened.
- R8: A write of a different nonzero-multiplier value during a lock interval restarts the lock count from zero. The interval then ends `LOCK_CYCLES` cycles after that write, and `mult_o` takes the newest value.
- R9: `clk_sel_o` only takes the codes 0, 1 and 2. It is 0 exactly when `lock_busy_o` is high. It changes only on rising oscillator clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | CTRL_W (4) | Control register write data |
| clk_sel_o | output | 2 | Clock source select: 0 half oscillator, 1 PLL, 2 bypass |
| mult_o | output | CTRL_W-1 (3) | Multiplier currently applied |
| lock_busy_o | output | 1 | High while the lock interval runs |

## Verification
An accepted write shows up on `clk_sel_o` and `lock_busy_o` one rising edge after the edge that samples the strobe. The end of the lock interval comes `LOCK_CYCLES` edges after that same edge. The bench drives inputs on falling edges and samples on falling edges. It counts edges from the write, so it checks the last busy cycle and the first cycle after it exactly. A short `LOCK_CYCLES` lets it sweep every ordered pair of register values, plus the restart, cancel and repeated-write cases.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;
  typedef enum logic [1:0] {
    SEL_HALF   = 2'd0,
    SEL_PLL    = 2'd1,
    SEL_BYPASS = 2'd2
  } clk_sel_e;
endpackage

// File: rtl/pll_ctrl_reg.sv
`timescale 1ns/1ps
module pll_ctrl_reg #(
  parameter int CTRL_W = 4,
  localparam int MULT_W = CTRL_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic              start_o,
  output logic              bypass_o,
  output logic [MULT_W-1:0] target_mult_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              accept;

  assign accept        = wr_en_i && (wr_data_i != ctrl_q);
  assign start_o       = accept && (wr_data_i[CTRL_W-1:1] != '0);
  assign bypass_o      = accept && (wr_data_i[CTRL_W-1:1] == '0);
  assign target_mult_o = ctrl_q[CTRL_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (accept) ctrl_q <= wr_data_i;
  end

  assert_same_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == ctrl_q) |=> $stable(ctrl_q));
  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ctrl_q == $past(wr_data_i));
endmodule

// File: rtl/pll_lock_timer.sv
`timescale 1ns/1ps
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 131072,
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST) && !start_i && !abort_i;

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_restart_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && cnt_q == '0));
  assert_cnt_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && !abort_i && cnt_q != LAST) |=>
      (busy_q && cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_abort_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !start_i) |=> !busy_q);
endmodule

// File: rtl/pll_sel_out.sv
`timescale 1ns/1ps
module pll_sel_out
  import pll_seq_pkg::*;
#(
  parameter int MULT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              bypass_i,
  input  logic              busy_i,
  input  logic [MULT_W-1:0] target_mult_i,
  output logic [MULT_W-1:0] mult_o,
  output clk_sel_e          clk_sel_o
);
  logic [MULT_W-1:0] applied_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       applied_q <= '0;
    else if (bypass_i) applied_q <= '0;
    else if (done_i)   applied_q <= target_mult_i;
  end

  always_comb begin
    if (busy_i)                clk_sel_o = SEL_HALF;
    else if (applied_q == '0)  clk_sel_o = SEL_BYPASS;
    else                       clk_sel_o = SEL_PLL;
  end

  assign mult_o = applied_q;

  assert_mult_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !bypass_i) |=> $stable(applied_q));
  assert_bypass_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> applied_q == '0);
endmodule

// File: rtl/pll_relock_seq.sv
`timescale 1ns/1ps
module pll_relock_seq
  import pll_seq_pkg::*;
#(
  parameter int CTRL_W      = 4,
  parameter int LOCK_CYCLES = 131072,
  localparam int MULT_W = CTRL_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [1:0]        clk_sel_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              lock_busy_o
);
  logic              start, bypass, done, busy;
  logic [MULT_W-1:0] target_mult;
  clk_sel_e          sel;

  pll_ctrl_reg #(.CTRL_W(CTRL_W)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .start_o(start), .bypass_o(bypass), .target_mult_o(target_mult)
  );

  pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .abort_i(bypass),
    .busy_o(busy), .done_o(done)
  );

  pll_sel_out #(.MULT_W(MULT_W)) u_sel (
    .clk_i, .rst_ni, .done_i(done), .bypass_i(bypass), .busy_i(busy),
    .target_mult_i(target_mult), .mult_o(mult_o), .clk_sel_o(sel)
  );

  assign clk_sel_o   = sel;
  assign lock_busy_o = busy;

  assert_sel_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_o != 2'd3);
  assert_busy_iff_half_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_busy_o == (clk_sel_o == 2'd0));
  assert_pll_has_mult_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_o == 2'd1) |-> (mult_o != '0));
endmodule

// File: tb/pll_relock_seq_bench.sv
`timescale 1ns/1ps
module pll_relock_seq_bench;
  localparam int CW = 4;
  localparam int L  = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [CW-1:0] wr_data_i = '0;
  logic [1:0]    clk_sel_o;
  logic [CW-2:0] mult_o;
  logic          lock_busy_o;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  pll_relock_seq #(.CTRL_W(CW), .LOCK_CYCLES(L)) u_pll_relock_seq (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .clk_sel_o, .mult_o, .lock_busy_o
  );

  always #2.5 clk_i = ~clk_i;

  task automatic check_out(input string req, input logic [1:0] esel,
                           input logic [CW-2:0] emult, input logic ebusy);
    vectors++;
    if (clk_sel_o !== esel || mult_o !== emult || lock_busy_o !== ebusy) begin
      fails++;
      $display("FAIL %s: sel/mult/busy = %0d/%0d/%0d expected %0d/%0d/%0d",
               req, clk_sel_o, mult_o, lock_busy_o, esel, emult, ebusy);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [CW-1:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  function automatic logic [1:0] steady_sel(input logic [CW-2:0] m);
    return (m == 0) ? 2'd2 : 2'd1;
  endfunction

  // write d onto register reg_v (applied mult cur), check full timeline; returns new applied mult
  task automatic write_and_track(input logic [CW-1:0] reg_v, input logic [CW-1:0] d,
                                 inout logic [CW-2:0] cur);
    logic [CW-2:0] nm;
    nm = d[CW-1:1];
    wr(d);
    if (d == reg_v) begin
      check_out("R7 same value ignored", steady_sel(cur), cur, 1'b0);
    end else if (nm == 0) begin
      check_out("R6 bypass immediate", 2'd2, '0, 1'b0);
      idle(L);
      check_out("R6 no lock started", 2'd2, '0, 1'b0);
      cur = '0;
    end else begin
      check_out("R2 lock start", 2'd0, cur, 1'b1);
      idle(L - 1);
      check_out("R3/R5 last busy cycle", 2'd0, cur, 1'b1);
      idle(1);
      check_out("R4 lock done", 2'd1, nm, 1'b0);
      cur = nm;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-2:0] cur;
    do_reset();
    check_out("R1 reset state", 2'd2, '0, 1'b0);

    // R2 R3 R4 R5 R6 R7: all ordered pairs of register values
    for (int a = 0; a < (1 << CW); a++) begin
      for (int b = 0; b < (1 << CW); b++) begin
        do_reset();
        cur = '0;
        write_and_track('0, CW'(a), cur);
        write_and_track(CW'(a), CW'(b), cur);
      end
    end

    // R8: restart during lock (8 then 6 after 5 cycles)
    do_reset();
    wr(4'd8);
    idle(5);
    wr(4'd6);
    check_out("R8 restart busy", 2'd0, '0, 1'b1);
    idle(L - 1);
    check_out("R8 restarted interval full length", 2'd0, '0, 1'b1);
    idle(1);
    check_out("R8 newest target applied", 2'd1, 3'd3, 1'b0);

    // R7: repeat write during lock does not extend it
    do_reset();
    wr(4'd8);
    idle(5);
    wr(4'd8);
    idle(L - 1 - 6);
    check_out("R7 lock not restarted", 2'd0, '0, 1'b1);
    idle(1);
    check_out("R7 lock ends on original schedule", 2'd1, 3'd4, 1'b0);

    // R6: bypass write cancels a running lock
    do_reset();
    wr(4'd4);
    idle(L);
    check_out("R4 value 4 gives x2", 2'd1, 3'd2, 1'b0);
    wr(4'd8);
    idle(3);
    wr(4'd0);
    check_out("R6 abort lock", 2'd2, '0, 1'b0);
    idle(L + 2);
    check_out("R6 stays bypass", 2'd2, '0, 1'b0);

    // R9: select stable between edges
    wr(4'd10);
    #1;
    check_out("R9 select only on edges", 2'd0, '0, 1'b1);
    idle(L);
    check_out("R9 pll select", 2'd1, 3'd5, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule